// File: doc/BRIEF.md
# Two-Context Coarse-Grain Thread Switch Controller

This controller sits beside a five-stage in-order pipeline (fetch, decode, execute, memory, write-back) that holds two hardware thread contexts. It owns one fetch program counter per thread. It drives the fetch address and a thread ID, and the datapath uses that ID to choose the general-register bank and the address-translation context. When a thread hits a long-latency cache miss, the controller moves fetch to the other thread in the same cycle, so the pipeline does not stall for the whole memory latency.

On an instruction-cache miss, the missing fetch slot becomes a bubble. The other thread starts fetching on the next cycle, and the missing thread will restart at the address that missed. On a data-cache miss in the memory stage, the controller squashes every younger instruction of that thread still in fetch, decode or execute. It saves the address of the missing instruction as the restart point and switches threads. A thread that is waiting becomes eligible again only when its refill-done strobe arrives. If both threads are waiting, fetch idles until one of them is released.

The controller keeps its own valid bit and thread tag for each of the decode, execute and memory stages. From these it knows which in-flight instructions belong to the thread that missed. It assumes the pipeline advances every cycle.

Top module: `cgmt_switch_ctrl`

## Requirements
- R1: After reset, thread 0 fetches from RST_PC0 with fetch_valid high, fetch_tid 0 and flush 000. Thread 1 is ready, and its first fetch uses RST_PC1.
- R2: While the running thread has no miss, it keeps fetching. Its fetch_pc advances by STEP bytes every cycle and fetch_tid stays the same.
- R3: An instruction-cache miss on a valid fetch sets flush bit 0 (the fetch stage) in that cycle. The missing address becomes that thread's restart PC. In the next cycle fetch moves to the other thread if that thread is ready.
- R4: A data-cache miss on a valid memory-stage instruction sets flush bit 0 (fetch), bit 1 (decode) and bit 2 (execute) for each of those stages that holds an instruction of the missing thread. Fetch moves to the other thread in the next cycle if that thread is ready.
- R5: A thread that stopped on a data-cache miss resumes fetching at the dmiss_pc it reported.
- R6: A waiting thread is never fetched before its refill_done bit (bit n for thread n) has been seen. A refill for a thread that is not running does not redirect fetch.
- R7: When both threads are waiting, fetch_valid stays low, including in the cycle the first refill strobe arrives. On the next cycle the released thread resumes.
- R8: If both threads are released in the same cycle while fetch is idle, the thread that was not the last to run resumes first.
- R9: A dmiss strobe in a cycle when the memory stage holds a bubble or a squashed slot has no effect on fetch or flush.
- R10: flush is nonzero only in a cycle that carries a miss. It is 000 in the cycle after one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| imiss | input | 1 | Instruction-cache miss for the current fetch |
| dmiss | input | 1 | Data-cache miss for the instruction in the memory stage |
| dmiss_pc | input | PC_W | Address of the instruction that missed in the data cache |
| refill_done | input | 2 | Refill completed; bit n releases thread n |
| fetch_valid | output | 1 | A fetch is issued this cycle |
| fetch_pc | output | PC_W | Fetch address |
| fetch_tid | output | 1 | Running thread; selects the register bank and address mapping |
| flush | output | 3 | Squash marks: bit 0 fetch, bit 1 decode, bit 2 execute |

## Verification
The properties assume that each thread has at most one outstanding miss. So no data-cache miss is reported for a thread that is already waiting, and a refill strobe comes only for a thread that is waiting. They also assume the pipeline never stalls, which means a stage's tag moves forward every cycle. The stimulus raises dmiss only when the memory stage holds an instruction of a running thread (apart from one deliberate strobe on a bubble), and it pairs each refill with a single earlier miss. Expected fetch addresses are derived in the bench by counting fetches from the restart points.

// File: rtl/cgmt_switch_ctrl.sv
module cgmt_switch_ctrl #(
  parameter int PC_W = 32,
  parameter int STEP = 4,
  parameter logic [PC_W-1:0] RST_PC0 = 'h1000,
  parameter logic [PC_W-1:0] RST_PC1 = 'h2000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            imiss,
  input  logic            dmiss,
  input  logic [PC_W-1:0] dmiss_pc,
  input  logic [1:0]      refill_done,
  output logic            fetch_valid,
  output logic [PC_W-1:0] fetch_pc,
  output logic            fetch_tid,
  output logic [2:0]      flush
);

  logic [PC_W-1:0] pc_q [2];
  logic [1:0] blk_q, blk_n;
  logic cur_q, go_other;
  logic id_v, ex_v, mem_v;
  logic id_t, ex_t, mem_t;
  logic im, dm, kill_if;

  assign fetch_valid = !blk_q[cur_q];
  assign fetch_pc    = pc_q[cur_q];
  assign fetch_tid   = cur_q;

  assign im      = imiss && fetch_valid;
  assign dm      = dmiss && mem_v;
  assign kill_if = dm && fetch_valid && (mem_t == cur_q);
  assign flush   = {dm && ex_v && (ex_t == mem_t),
                    dm && id_v && (id_t == mem_t),
                    im || kill_if};

  always_comb begin
    blk_n = blk_q & ~refill_done;
    if (im) blk_n[cur_q] = 1'b1;
    if (dm) blk_n[mem_t] = 1'b1;
  end

  assign go_other = !blk_n[~cur_q] && (blk_n[cur_q] || blk_q[cur_q]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q[0] <= RST_PC0;
      pc_q[1] <= RST_PC1;
      blk_q   <= 2'b00;
      cur_q   <= 1'b0;
      id_v    <= 1'b0;
      ex_v    <= 1'b0;
      mem_v   <= 1'b0;
      id_t    <= 1'b0;
      ex_t    <= 1'b0;
      mem_t   <= 1'b0;
    end else begin
      for (int i = 0; i < 2; i++) begin
        if (dm && mem_t == i[0])
          pc_q[i] <= dmiss_pc;
        else if (cur_q == i[0] && fetch_valid && !im)
          pc_q[i] <= pc_q[i] + PC_W'(STEP);
      end
      blk_q <= blk_n;
      cur_q <= go_other ? ~cur_q : cur_q;
      id_v  <= fetch_valid && !im && !kill_if;
      id_t  <= cur_q;
      ex_v  <= id_v && !flush[1];
      ex_t  <= id_t;
      mem_v <= ex_v && !flush[2];
      mem_t <= ex_t;
    end
  end

endmodule

// File: rtl/cgmt_switch_ctrl_chk.sv
module cgmt_switch_ctrl_chk #(
  parameter int PC_W = 32,
  parameter int STEP = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            imiss,
  input logic            dmiss,
  input logic [1:0]      refill_done,
  input logic            fetch_valid,
  input logic [PC_W-1:0] fetch_pc,
  input logic            fetch_tid,
  input logic [2:0]      flush
);

  AST_FLUSH_NEEDS_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    (flush != 3'b000) |-> ((imiss && fetch_valid) || dmiss)); // R10

  AST_IMISS_MARKS_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    (imiss && fetch_valid) |-> flush[0]); // R3

  AST_IMISS_LEAVES_THREAD: assert property (@(posedge clk) disable iff (!rst_n)
    (imiss && fetch_valid) |=> (!fetch_valid || fetch_tid != $past(fetch_tid))); // R3

  AST_STEADY_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid && flush == 3'b000) |=>
      (fetch_valid && fetch_tid == $past(fetch_tid) &&
       fetch_pc == $past(fetch_pc) + PC_W'(STEP))); // R2

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!fetch_valid && refill_done == 2'b00) |=> !fetch_valid); // R7

  AST_WAKE_NEEDS_REFILL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fetch_valid) |-> ($past(refill_done) != 2'b00)); // R6

endmodule

bind cgmt_switch_ctrl cgmt_switch_ctrl_chk #(.PC_W(PC_W), .STEP(STEP)) u_chk (
  .clk(clk), .rst_n(rst_n), .imiss(imiss), .dmiss(dmiss),
  .refill_done(refill_done), .fetch_valid(fetch_valid), .fetch_pc(fetch_pc),
  .fetch_tid(fetch_tid), .flush(flush)
);

// File: tb/tb_cgmt_switch_ctrl.sv
`timescale 1ns/1ps
module tb_cgmt_switch_ctrl;
  localparam int PC_W = 32;

  logic clk = 1'b0;
  logic rst_n;
  logic imiss, dmiss;
  logic [PC_W-1:0] dmiss_pc;
  logic [1:0] refill_done;
  logic fetch_valid, fetch_tid;
  logic [PC_W-1:0] fetch_pc;
  logic [2:0] flush;

  int total = 0;
  int bad = 0;
  bit done = 0;

  typedef struct {
    logic            v;
    logic            tid;
    logic [PC_W-1:0] pc;
    logic [2:0]      fl;
    string           tag;
  } exp_t;
  exp_t sb[$];

  always #5 clk = ~clk;

  cgmt_switch_ctrl #(.PC_W(PC_W), .STEP(4), .RST_PC0('h1000), .RST_PC1('h2000)) dut (
    .clk(clk), .rst_n(rst_n), .imiss(imiss), .dmiss(dmiss), .dmiss_pc(dmiss_pc),
    .refill_done(refill_done), .fetch_valid(fetch_valid), .fetch_pc(fetch_pc),
    .fetch_tid(fetch_tid), .flush(flush)
  );

  task automatic step(input logic ic, input logic dc, input logic [PC_W-1:0] dpc,
                      input logic [1:0] rd, input logic ev, input logic et,
                      input logic [PC_W-1:0] epc, input logic [2:0] efl, input string tag);
    exp_t e;
    @(negedge clk);
    imiss = ic; dmiss = dc; dmiss_pc = dpc; refill_done = rd;
    e.v = ev; e.tid = et; e.pc = epc; e.fl = efl; e.tag = tag;
    sb.push_back(e);
  endtask

  initial begin
    forever begin
      @(negedge clk);
      #3;
      if (sb.size() > 0) begin
        exp_t e;
        logic ok;
        e = sb.pop_front();
        ok = (fetch_valid === e.v) && (flush === e.fl);
        if (e.v) ok = ok && (fetch_tid === e.tid) && (fetch_pc === e.pc);
        total++;
        if (!ok) begin
          bad++;
          $display("FAIL %s: got v=%0d tid=%0d pc=%h flush=%b, expected v=%0d tid=%0d pc=%h flush=%b",
                   e.tag, fetch_valid, fetch_tid, fetch_pc, flush, e.v, e.tid, e.pc, e.fl);
        end
      end
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; imiss = 0; dmiss = 0; dmiss_pc = '0; refill_done = 2'b00;
    step(0, 0, 0, 2'b00, 1, 0, 'h1000, 3'b000, "R1 reset state");
    @(posedge clk); #1 rst_n = 1'b1;
    for (int i = 0; i < 4; i++)
      step(0, 0, 0, 2'b00, 1, 0, 'h1000 + 4*i, 3'b000, "R2 sequential thread 0");
    step(1, 0, 0, 2'b00, 1, 0, 'h1010, 3'b001, "R3 imiss marks fetch");
    for (int i = 0; i < 19; i++) begin
      if (i == 0)
        step(0, 0, 0, 2'b00, 1, 1, 'h2000, 3'b000, "R1 thread 1 reset pc after R3 switch");
      else if (i == 2)
        step(0, 1, 'hDEAD, 2'b00, 1, 1, 'h2008, 3'b000, "R9 dmiss on bubble ignored");
      else
        step(0, 0, 0, 2'b00, 1, 1, 'h2000 + 4*i, 3'b000, "R2 sequential thread 1");
    end
    step(0, 0, 0, 2'b01, 1, 1, 'h204C, 3'b000, "R6 refill of other thread no redirect");
    step(0, 0, 0, 2'b00, 1, 1, 'h2050, 3'b000, "R6 thread 1 keeps running");
    step(0, 0, 0, 2'b00, 1, 1, 'h2054, 3'b000, "R2 sequential thread 1");
    step(0, 1, 'h204C, 2'b00, 1, 1, 'h2058, 3'b111, "R4 dmiss squashes younger");
    step(0, 0, 0, 2'b00, 1, 0, 'h1010, 3'b000, "R3 restart at missed fetch, R10 flush cleared");
    for (int i = 1; i < 4; i++)
      step(0, 0, 0, 2'b00, 1, 0, 'h1010 + 4*i, 3'b000, "R2 sequential thread 0");
    step(1, 0, 0, 2'b00, 1, 0, 'h1020, 3'b001, "R3 imiss with other waiting");
    for (int i = 0; i < 14; i++)
      step(0, 0, 0, 2'b00, 0, 0, 0, 3'b000, "R7 both waiting idle");
    step(0, 0, 0, 2'b10, 0, 0, 0, 3'b000, "R7 idle in refill cycle");
    step(0, 0, 0, 2'b00, 1, 1, 'h204C, 3'b000, "R5 restart at dmiss pc");
    step(0, 0, 0, 2'b00, 1, 1, 'h2050, 3'b000, "R2 sequential thread 1");
    step(1, 0, 0, 2'b00, 1, 1, 'h2054, 3'b001, "R3 imiss thread 1");
    step(0, 0, 0, 2'b00, 0, 0, 0, 3'b000, "R7 both waiting idle");
    step(0, 0, 0, 2'b11, 0, 0, 0, 3'b000, "R7 idle in joint refill cycle");
    step(0, 0, 0, 2'b00, 1, 0, 'h1020, 3'b000, "R8 joint release picks other thread");
    step(1, 0, 0, 2'b00, 1, 0, 'h1024, 3'b001, "R3 imiss thread 0");
    step(0, 0, 0, 2'b00, 1, 1, 'h2054, 3'b000, "R3 switch to thread 1");
    step(0, 0, 0, 2'b00, 1, 1, 'h2058, 3'b000, "R2 sequential thread 1");
    step(0, 0, 0, 2'b00, 1, 1, 'h205C, 3'b000, "R2 sequential thread 1");
    step(0, 1, 'h2054, 2'b00, 1, 1, 'h2060, 3'b111, "R4 dmiss squashes younger");
    step(0, 0, 0, 2'b00, 0, 0, 0, 3'b000, "R7 both waiting after R4");
    step(0, 0, 0, 2'b11, 0, 0, 0, 3'b000, "R7 idle in joint refill cycle");
    step(0, 0, 0, 2'b00, 1, 0, 'h1024, 3'b000, "R8 joint release picks other thread");
    step(1, 0, 0, 2'b00, 1, 0, 'h1028, 3'b001, "R3 imiss thread 0");
    step(0, 0, 0, 2'b00, 1, 1, 'h2054, 3'b000, "R5 restart at dmiss pc");
    step(0, 0, 0, 2'b00, 1, 1, 'h2058, 3'b000, "R10 flush clear");
    @(negedge clk); imiss = 0; dmiss = 0; refill_done = 2'b00;
    @(negedge clk); #5;
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule